// File: doc/BRIEF.md
# EEPROM Page Write and Address Unit

This block sits between a serial-bus front end and the storage array of a small byte-wide EEPROM. A write session opens with a starting byte address. Data bytes that follow are gathered into a one-page buffer. A stop indication then commits every byte that was collected to the array as one timed internal write. While that write runs, the block reports busy.

The block also keeps the current-address register that reads use. A read returns the byte at the current address and moves the register on by one. The address wraps from the top of the array to zero. A write session that carries no data bytes sets the current address and writes nothing, which is how a random read is aimed. The array is an internal register memory with one write port and one registered read port, and it can be mapped to block RAM.

Top module: `eeprom_page_unit`

## Requirements
- R1: After synchronous reset, `busy` is 0, `rd_vld` is 0 and `cur_addr` is 0.
- R2: Consider a session that opens at address A with `sess_start` and accepts bytes D0..Dk-1 through `byte_vld`. Byte Di lands at the address whose high bits (above the low `PAGE_W` bits) equal those of A and whose low `PAGE_W` bits equal (A + i) mod 2^PAGE_W. The array can be read at those addresses once `busy` has fallen.
- R3: If more than 2^PAGE_W bytes arrive in one session, the in-page index wraps and later bytes overwrite earlier ones. The high address bits never change during a session. After each accepted byte, `cur_addr` holds the page base plus the next in-page index.
- R4: Page locations that receive no byte in a session keep their earlier contents.
- R5: The array is written only after `sess_stop`. If at least one byte was accepted, `busy` rises on the clock edge that samples `sess_stop` and stays high for exactly `WR_CYCLES` cycles, where `WR_CYCLES` ≥ 2^PAGE_W. A session with no bytes leaves `busy` low. `sess_stop` takes priority over `byte_vld` in the same cycle.
- R6: When idle and not busy, a `rd_req` makes `rd_vld` high in the next cycle, with `rd_data` equal to the byte at the old `cur_addr`. At the same edge, `cur_addr` increments by one.
- R7: A read at the top address (all ones) moves `cur_addr` to 0.
- R8: While `busy` is high, `sess_start` and `rd_req` are ignored: `rd_vld` stays 0 and `cur_addr` does not change.
- R9: An accepted `sess_start` loads `cur_addr` with `sess_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_start | input | 1 | Open a write session at `sess_addr` (idle only) |
| sess_addr | input | ADDR_W | Starting byte address |
| byte_vld | input | 1 | Data byte strobe during a session |
| byte_in | input | DATA_W | Data byte |
| sess_stop | input | 1 | Close the session; commit if any byte was taken |
| rd_req | input | 1 | Read the byte at `cur_addr` |
| rd_data | output | DATA_W | Read data, valid with `rd_vld` |
| rd_vld | output | 1 | Read data strobe, one cycle after `rd_req` |
| busy | output | 1 | Internal write cycle in progress |
| cur_addr | output | ADDR_W | Current address register |

## Verification
The bench fills every page with sessions that start at a non-zero offset and wrap, then reads the whole array back in sequence and carries on past the top address. A design that carried the in-page increment into the page bits, or that stopped at the top instead of wrapping, would return bytes from the wrong page. A short session inside a page that was already written shows whether untouched bytes survive; a design that committed the whole buffer would zero them. A 20-byte session shows whether later bytes overwrite earlier ones. Reads and session starts issued during busy show whether a design lets requests through in the middle of a write. The busy count is compared with `WR_CYCLES` on every commit.

// File: rtl/epw_pkg.sv
package epw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_COMMIT  = 2'd2
  } epw_state_t;
endpackage

// File: rtl/epw_page_buf.sv
module epw_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PAGE_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rmask,
  output logic              any_set
);
  localparam int PAGE = 1 << PAGE_W;

  logic [DATA_W-1:0] slot [PAGE];
  logic [PAGE-1:0]   mask;

  always_ff @(posedge clk) begin
    if (we) slot[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mask <= '0;
    else if (we)    mask[widx] <= 1'b1;
  end

  assign rdata   = slot[ridx];
  assign rmask   = mask[ridx];
  assign any_set = |mask;
endmodule

// File: rtl/epw_array.sv
module epw_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/epw_ctrl.sv
module epw_ctrl
  import epw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sess_start,
  input  logic [ADDR_W-1:0] sess_addr,
  input  logic              byte_vld,
  input  logic              sess_stop,
  input  logic              rd_req,
  input  logic              buf_any,
  input  logic              buf_mask,
  output logic              buf_clr,
  output logic              buf_we,
  output logic [PAGE_W-1:0] buf_widx,
  output logic [PAGE_W-1:0] buf_ridx,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic              arr_re,
  output logic              rd_vld,
  output logic              busy,
  output logic              collecting,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W  = ADDR_W - PAGE_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  epw_state_t        state;
  logic [HI_W-1:0]   base;
  logic [PAGE_W-1:0] ptr;
  logic [CNT_W-1:0]  cnt;

  wire idle_ok = (state == ST_IDLE);

  always_comb begin
    buf_clr   = idle_ok && sess_start;
    buf_we    = (state == ST_COLLECT) && byte_vld && !sess_stop;
    buf_widx  = ptr;
    buf_ridx  = cnt[PAGE_W-1:0];
    arr_we    = (state == ST_COMMIT) && (cnt < CNT_W'(PAGE)) && buf_mask;
    arr_waddr = {base, cnt[PAGE_W-1:0]};
    arr_re    = idle_ok && !sess_start && rd_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      base     <= '0;
      ptr      <= '0;
      cnt      <= '0;
      cur_addr <= '0;
      rd_vld   <= 1'b0;
    end else begin
      rd_vld <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (sess_start) begin
            base     <= sess_addr[ADDR_W-1:PAGE_W];
            ptr      <= sess_addr[PAGE_W-1:0];
            cur_addr <= sess_addr;
            state    <= ST_COLLECT;
          end else if (rd_req) begin
            cur_addr <= cur_addr + 1'b1;
            rd_vld   <= 1'b1;
          end
        end
        ST_COLLECT: begin
          if (sess_stop) begin
            cnt   <= '0;
            state <= buf_any ? ST_COMMIT : ST_IDLE;
          end else if (byte_vld) begin
            ptr      <= ptr + 1'b1;
            cur_addr <= {base, ptr + 1'b1};
          end
        end
        ST_COMMIT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(WR_CYCLES - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state == ST_COMMIT);
  assign collecting = (state == ST_COLLECT);
endmodule

// File: rtl/eeprom_page_unit.sv
module eeprom_page_unit #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sess_start,
  input  logic [ADDR_W-1:0] sess_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              sess_stop,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr
);
  logic              buf_clr, buf_we, buf_mask, buf_any;
  logic [PAGE_W-1:0] buf_widx, buf_ridx;
  logic [DATA_W-1:0] buf_rdata;
  logic              arr_we, arr_re;
  logic [ADDR_W-1:0] arr_waddr;
  logic              collecting;

  epw_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .sess_start(sess_start), .sess_addr(sess_addr),
    .byte_vld(byte_vld), .sess_stop(sess_stop), .rd_req(rd_req),
    .buf_any(buf_any), .buf_mask(buf_mask), .buf_clr(buf_clr),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_ridx(buf_ridx),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_re(arr_re),
    .rd_vld(rd_vld), .busy(busy), .collecting(collecting),
    .cur_addr(cur_addr)
  );

  epw_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .we(buf_we), .widx(buf_widx),
    .wdata(byte_in), .ridx(buf_ridx), .rdata(buf_rdata),
    .rmask(buf_mask), .any_set(buf_any)
  );

  epw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(buf_rdata),
    .re(arr_re), .raddr(cur_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/eeprom_page_unit_chk.sv
module eeprom_page_unit_chk #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              sess_stop,
  input logic              rd_req,
  input logic              rd_vld,
  input logic              busy,
  input logic              collecting,
  input logic [ADDR_W-1:0] cur_addr
);
  logic [15:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  a_r6_vld_follows_req: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(rd_req));

  a_r6_r7_cur_step: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

  a_r8_busy_blocks_read: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_req) |=> !rd_vld);

  a_r8_busy_holds_addr: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cur_addr));

  a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(sess_stop));

  a_r5_busy_cap: assert property (@(posedge clk) disable iff (rst)
    bcnt <= 16'(WR_CYCLES));

  a_r5_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> bcnt == 16'(WR_CYCLES));

  a_r3_page_fixed: assert property (@(posedge clk) disable iff (rst)
    (collecting && $past(collecting)) |->
      cur_addr[ADDR_W-1:PAGE_W] == $past(cur_addr[ADDR_W-1:PAGE_W]));
endmodule

bind eeprom_page_unit eeprom_page_unit_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .sess_stop(sess_stop), .rd_req(rd_req),
  .rd_vld(rd_vld), .busy(busy), .collecting(collecting), .cur_addr(cur_addr)
);

// File: tb/tb_eeprom_page_unit.sv
module tb_eeprom_page_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int PAGE_W = 4;
  localparam int DATA_W = 8;
  localparam int WR_CYCLES = 20;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE = 1 << PAGE_W;

  logic clk = 0, rst = 1;
  logic sess_start = 0, byte_vld = 0, sess_stop = 0, rd_req = 0;
  logic [ADDR_W-1:0] sess_addr = '0;
  logic [DATA_W-1:0] byte_in = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_vld, busy;
  logic [ADDR_W-1:0] cur_addr;

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] mdl [DEPTH];
  logic [ADDR_W-1:0] mcur;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_page_unit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                     .WR_CYCLES(WR_CYCLES)) dut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_busy(int n_bytes);
    int len = 0;
    if (n_bytes == 0) chk("R5 no busy on empty session", busy, 0);
    else chk("R5 busy rises with stop", busy, 1);
    while (busy && len < 1000) begin step(); len++; end
    if (n_bytes != 0) chk("R5 busy length", len, WR_CYCLES);
  endtask

  task automatic session(int addr, int n, int seed);
    logic [DATA_W-1:0] pb [PAGE];
    bit wr [PAGE];
    int hi = addr & ~(PAGE - 1);
    for (int i = 0; i < PAGE; i++) wr[i] = 0;
    sess_start = 1; sess_addr = ADDR_W'(addr); step(); sess_start = 0;
    chk("R9 start loads cur_addr", cur_addr, addr);
    for (int i = 0; i < n; i++) begin
      int idx = (addr + i) % PAGE;
      byte_vld = 1; byte_in = DATA_W'(seed + i * 37);
      pb[idx] = byte_in; wr[idx] = 1;
      step();
      chk("R3 cur_addr in page", cur_addr, hi + ((idx + 1) % PAGE));
    end
    byte_vld = 0;
    sess_stop = 1; step(); sess_stop = 0;
    for (int i = 0; i < PAGE; i++) if (wr[i]) mdl[hi + i] = pb[i];
    mcur = (n == 0) ? ADDR_W'(addr) : ADDR_W'(hi + ((addr + n) % PAGE));
    wait_busy(n);
  endtask

  task automatic rd_chk(string req);
    logic [ADDR_W-1:0] a = mcur;
    rd_req = 1; step(); rd_req = 0;
    chk({req, " rd_vld"}, rd_vld, 1);
    chk({req, " rd_data"}, rd_data, mdl[a]);
    mcur = mcur + 1'b1;
    chk({req, " cur_addr step"}, cur_addr, mcur);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step(); rst = 0; step();
    chk("R1 busy", busy, 0);
    chk("R1 rd_vld", rd_vld, 0);
    chk("R1 cur_addr", cur_addr, 0);

    // R5/R9: empty session sets address, no commit
    session(8'h40, 0, 0);

    // R2/R3: fill every page from a rotating offset, full wrap
    for (int p = 0; p < DEPTH / PAGE; p++)
      session(p * PAGE + (p % PAGE), PAGE, p * 11 + 5);

    // R2/R6/R7: full sequential read and past the top
    session(0, 0, 0);
    for (int a = 0; a < DEPTH + 3; a++) rd_chk("R6 R7 seq read");

    // R4: short session leaves other bytes alone
    session(8'h25, 3, 8'hA0);
    // R3: overlong session overwrites earlier bytes
    session(8'h3E, 20, 8'h11);
    session(8'h20, 0, 0);
    for (int a = 0; a < 2 * PAGE; a++) rd_chk("R3 R4 readback");

    // R8: requests during busy are ignored
    session(8'h50, 2, 8'h77);  // finishes busy; start another and poke mid-busy
    sess_start = 1; sess_addr = 8'h60; step(); sess_start = 0;
    byte_vld = 1; byte_in = 8'h5A; step(); byte_vld = 0;
    sess_stop = 1; step(); sess_stop = 0;
    mdl[8'h60] = 8'h5A; mcur = 8'h61;
    chk("R8 busy high", busy, 1);
    rd_req = 1; step(); rd_req = 0;
    chk("R8 read ignored rd_vld", rd_vld, 0);
    chk("R8 read ignored cur_addr", cur_addr, 8'h61);
    sess_start = 1; sess_addr = 8'h99; step(); sess_start = 0;
    chk("R8 start ignored cur_addr", cur_addr, 8'h61);
    while (busy) step();
    chk("R8 cur_addr after busy", cur_addr, 8'h61);
    session(8'h5F, 0, 0);
    rd_chk("R8 R6 after busy");
    rd_chk("R8 R6 committed byte");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule